// File: doc/BRIEF.md
# PHY Initialization Sync Sequencer

This block runs the self-timed start-up of a storage-card PHY. Firmware writes a single 32-bit control word. Setting the top bit of that word launches a hardware sequence. The sequence raises a sync-enable strobe, leaves a quiet gap, raises a sync-reset strobe, waits for the PHY to settle, and then spends a fixed tail of extra cycles. Each of the first four phases takes its length from its own 4-bit field of the same word. While the sequence runs, the launch bit reads back as 1. It drops to 0 by itself when the tail ends, so software can poll it.

The sequence must be run again whenever the card clock changes frequency, is stopped and restarted, or the timing or function settings change. The same word also holds a slow-mode bit, which tells the datapath to bypass the PHY, and an SDIO-mode bit. Both are exported as plain level outputs. A ready output is low for exactly the time the sequence runs.

Top module: `phyinit_sync`

## Requirements
- R1: After a synchronous active-high reset, all duration fields and both mode bits read 0, bit 31 reads 0, phy_ready is 1, and fc_sync_en and fc_sync_rst are 0.
- R2: A write with bit 31 set, made while the sequence is idle, starts the sequence. From the next cycle on, bit 31 reads 1 until the sequence ends, and then reads 0.
- R3: The sequence lasts exactly the sum of the four fields plus TAIL_CYCLES (default 8: 4 bus-clock and 4 interconnect-clock cycles) clock cycles.
- R4: Phase order and lengths are as follows. fc_sync_en is high for field [11:8] cycles. Both strobes are then low for field [7:4] cycles. fc_sync_rst is then high for field [3:0] cycles. Both strobes then stay low for field [15:12] cycles plus the tail. The two strobes are never high together.
- R5: A phase whose field is 0 takes zero cycles. With all fields 0, the sequence is only the tail.
- R6: A write with bit 31 set while the sequence runs does not restart or lengthen it.
- R7: phy_ready is 0 exactly in the cycles where bit 31 reads 1.
- R8: Bit 29 (slow mode) and bit 28 (SDIO mode) are read/write at any time and drive slow_mode and sdio_mode from the cycle after the write. Bits 30 and 27:16 always read 0.
- R9: A field write made while the sequence runs is visible on readback at once but does not change the timing of the running sequence. That sequence uses the field values captured at its start.
- R10: A write with bit 31 clear updates the fields and mode bits but does not start the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback, with bit 31 showing the busy state |
| fc_sync_en | output | 1 | Sync-enable strobe to the PHY |
| fc_sync_rst | output | 1 | Sync-reset strobe to the PHY |
| phy_ready | output | 1 | High when no initialization is in progress |
| slow_mode | output | 1 | Slow-mode (PHY bypass) level |
| sdio_mode | output | 1 | SDIO-mode level |

## Verification
The bench builds the block with its default TAIL_CYCLES of 8. At that value, the shortest sequence (all fields zero, 8 cycles) and the longest one (all fields 15, 68 cycles) both fit in short directed runs. Every phase-skip combination can be reached with a few chosen field patterns. Field width stays at 4 bits, so every phase length from 0 to 15, including the boundary values, can be driven directly.

// File: rtl/phyinit_pkg.sv
package phyinit_pkg;

    localparam int REG_W      = 32;
    localparam int FIELD_W    = 4;
    localparam int START_BIT  = 31;
    localparam int SLOW_BIT   = 29;
    localparam int SDIO_BIT   = 28;
    localparam int DUR_W      = 4 * FIELD_W;

    // Packed so that the struct maps directly onto word bits [15:0]:
    // settle [15:12], en [11:8], gap [7:4], rst [3:0]
    typedef struct packed {
        logic [FIELD_W-1:0] settle;
        logic [FIELD_W-1:0] en;
        logic [FIELD_W-1:0] gap;
        logic [FIELD_W-1:0] rst;
    } dur_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_EN,
        PH_GAP,
        PH_RST,
        PH_SETTLE,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic slow;
        logic sdio;
        dur_t dur;
    } cfg_t;

    function automatic dur_t word_to_dur(logic [REG_W-1:0] w);
        return dur_t'(w[DUR_W-1:0]);
    endfunction

    // Fixed successor in the sequence, with no skipping
    function automatic phase_e phase_succ(phase_e p);
        case (p)
            PH_IDLE:   return PH_EN;
            PH_EN:     return PH_GAP;
            PH_GAP:    return PH_RST;
            PH_RST:    return PH_SETTLE;
            PH_SETTLE: return PH_TAIL;
            default:   return PH_IDLE;
        endcase
    endfunction

    // Programmed length of a field-driven phase; 0 for the others
    function automatic logic [FIELD_W-1:0] field_len(phase_e p, dur_t d);
        case (p)
            PH_EN:     return d.en;
            PH_GAP:    return d.gap;
            PH_RST:    return d.rst;
            PH_SETTLE: return d.settle;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/phyinit_regs.sv
module phyinit_regs
    import phyinit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             busy_i,
    output logic             start_o,
    output cfg_t             cfg_o,
    output logic [REG_W-1:0] rd_data
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.slow <= wr_data[SLOW_BIT];
            cfg_q.sdio <= wr_data[SDIO_BIT];
            cfg_q.dur  <= word_to_dur(wr_data);
        end
    end

    // A launch request only counts while the sequencer is idle
    assign start_o = wr_en && wr_data[START_BIT] && !busy_i;
    assign cfg_o   = cfg_q;

    always_comb begin
        rd_data                 = '0;
        rd_data[START_BIT]      = busy_i;
        rd_data[SLOW_BIT]       = cfg_q.slow;
        rd_data[SDIO_BIT]       = cfg_q.sdio;
        rd_data[DUR_W-1:0]      = cfg_q.dur;
    end

    assert_mode_write_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg_o.slow == $past(wr_data[SLOW_BIT])) &&
                  (cfg_o.sdio == $past(wr_data[SDIO_BIT])));

    assert_field_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[DUR_W-1:0] == $past(wr_data[DUR_W-1:0]));

endmodule

// File: rtl/phyinit_seq.sv
module phyinit_seq
    import phyinit_pkg::*;
#(
    parameter int TAIL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  dur_t dur_i,
    output logic busy_o,
    output logic sync_en_o,
    output logic sync_rst_o
);

    localparam int MAX_LEN = (TAIL_CYCLES > (1 << FIELD_W)) ? TAIL_CYCLES : (1 << FIELD_W);
    localparam int CNT_W   = $clog2(MAX_LEN);
    localparam int LEN_W   = CNT_W + 1;
    localparam int N_PHASE = 5;

    phase_e            phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    dur_t              snap_q, snap_d;

    function automatic logic [LEN_W-1:0] len_of(phase_e p, dur_t d);
        if (p == PH_TAIL)
            return LEN_W'(TAIL_CYCLES);
        return LEN_W'(field_len(p, d));
    endfunction

    // From candidate p, walk forward past every phase of length zero
    function automatic phase_e first_live(phase_e p, dur_t d);
        phase_e q;
        q = p;
        for (int k = 0; k < N_PHASE; k++) begin
            if (q != PH_TAIL && q != PH_IDLE && len_of(q, d) == '0)
                q = phase_succ(q);
        end
        return q;
    endfunction

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        snap_d  = snap_q;
        if (phase_q == PH_IDLE) begin
            if (start_i) begin
                snap_d  = dur_i;
                phase_d = first_live(PH_EN, dur_i);
                cnt_d   = CNT_W'(len_of(phase_d, dur_i) - LEN_W'(1));
            end
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else if (phase_q == PH_TAIL) begin
            phase_d = PH_IDLE;
        end else begin
            phase_d = first_live(phase_succ(phase_q), snap_q);
            cnt_d   = CNT_W'(len_of(phase_d, snap_q) - LEN_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            snap_q  <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            snap_q  <= snap_d;
        end
    end

    assign busy_o     = (phase_q != PH_IDLE);
    assign sync_en_o  = (phase_q == PH_EN);
    assign sync_rst_o = (phase_q == PH_RST);

    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q != '0) |=> phase_q == $past(phase_q));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sync_en_o, sync_rst_o}));

    assert_launch_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    assert_no_relaunch_R6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !start_i);

    assert_tail_exit_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(phase_q) == PH_TAIL);

endmodule

// File: rtl/phyinit_sync.sv
module phyinit_sync
    import phyinit_pkg::*;
#(
    parameter int TAIL_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        fc_sync_en,
    output logic        fc_sync_rst,
    output logic        phy_ready,
    output logic        slow_mode,
    output logic        sdio_mode
);

    logic busy;
    logic start;
    cfg_t cfg;

    phyinit_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy_i  (busy),
        .start_o (start),
        .cfg_o   (cfg),
        .rd_data (rd_data)
    );

    phyinit_seq #(
        .TAIL_CYCLES (TAIL_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .dur_i      (word_to_dur(wr_data)),
        .busy_o     (busy),
        .sync_en_o  (fc_sync_en),
        .sync_rst_o (fc_sync_rst)
    );

    assign phy_ready = !busy;
    assign slow_mode = cfg.slow;
    assign sdio_mode = cfg.sdio;

    assert_ready_tracks_R7: assert property (@(posedge clk) disable iff (rst)
        phy_ready == !rd_data[START_BIT]);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> phy_ready && !fc_sync_en && !fc_sync_rst && rd_data == '0);

    assert_quiet_write_R10: assert property (@(posedge clk) disable iff (rst)
        (phy_ready && wr_en && !wr_data[START_BIT]) |=> phy_ready);

endmodule

// File: tb/phyinit_sync_test.sv
module phyinit_sync_test;

    localparam int CLK_PERIOD = 10;
    localparam int TAIL       = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        fc_sync_en, fc_sync_rst, phy_ready, slow_mode, sdio_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phyinit_sync #(.TAIL_CYCLES(TAIL)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fc_sync_en(fc_sync_en), .fc_sync_rst(fc_sync_rst),
        .phy_ready(phy_ready), .slow_mode(slow_mode), .sdio_mode(sdio_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(bit go, int s, int e, int g, int r);
        logic [31:0] w;
        w = '0;
        w[31]    = go;
        w[15:12] = 4'(s);
        w[11:8]  = 4'(e);
        w[7:4]   = 4'(g);
        w[3:0]   = 4'(r);
        return w;
    endfunction

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // Launch a run and compare every cycle with the expected waveform.
    // inj_at >= 0 drives a second write at that sample index.
    task automatic run_seq(input string req, input int s, input int e, input int g, input int r,
                           input int inj_at, input logic [31:0] inj_word);
        int total, busy_cnt, wave_bad, ready_bad;
        bit exp_en, exp_rst;
        total = s + e + g + r + TAIL;
        busy_cnt = 0; wave_bad = 0; ready_bad = 0;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = mkword(1'b1, s, e, g, r);
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            wr_en   = 1'b0;
            wr_data = '0;
            exp_en  = (i < e);
            exp_rst = (i >= e + g) && (i < e + g + r);
            if (rd_data[31]) busy_cnt++;
            if (rd_data[31] != (i < total)) wave_bad++;
            if (fc_sync_en != exp_en || fc_sync_rst != exp_rst) wave_bad++;
            if (phy_ready != !rd_data[31]) ready_bad++;
            if (i == inj_at) begin
                wr_en   = 1'b1;
                wr_data = inj_word;
            end
            if (i > total + 1) break;
        end
        check(busy_cnt == total, {req, " R2 R3 busy length"}, busy_cnt, total);
        check(wave_bad == 0, {req, " R4 phase waveform mismatches"}, wave_bad, 0);
        check(ready_bad == 0, {req, " R7 ready vs busy mismatches"}, ready_bad, 0);
    endtask

    task automatic t_reset;
        check(rd_data == 32'h0, "R1 readback after reset", int'(rd_data), 0);
        check(phy_ready && !fc_sync_en && !fc_sync_rst, "R1 outputs after reset",
              int'({phy_ready, fc_sync_en, fc_sync_rst}), 4);
    endtask

    task automatic t_basic;
        run_seq("R4 mixed", 5, 3, 2, 4, -1, '0);
        run_seq("R4 ones", 1, 1, 1, 1, -1, '0);
        check(rd_data[31] == 1'b0, "R2 start bit cleared", int'(rd_data[31]), 0);
    endtask

    task automatic t_skip;
        run_seq("R5 all zero", 0, 0, 0, 0, -1, '0);
        run_seq("R5 en and rst zero", 3, 0, 6, 0, -1, '0);
        run_seq("R5 gap and settle zero", 0, 7, 0, 2, -1, '0);
    endtask

    task automatic t_max;
        run_seq("R3 all max", 15, 15, 15, 15, -1, '0);
    endtask

    task automatic t_relaunch;
        // second launch mid-run with new fields: timing stays with the first
        run_seq("R6 relaunch ignored", 2, 4, 3, 2, 5, mkword(1'b1, 9, 9, 9, 9));
        check(rd_data[15:0] == 16'h9999, "R9 new fields on readback",
              int'(rd_data[15:0]), 16'h9999);
        run_seq("R9 quiet field write mid-run", 1, 2, 2, 2, 2, mkword(1'b0, 4, 4, 4, 4));
        check(rd_data[15:0] == 16'h4444, "R9 quiet write readback",
              int'(rd_data[15:0]), 16'h4444);
    endtask

    task automatic t_modes;
        write_word(32'h7FFF_FFFF & ~32'h0000_FFFF); // bit31 clear, 30:16 set
        check(slow_mode && sdio_mode, "R8 mode outputs set", int'({slow_mode, sdio_mode}), 3);
        check(rd_data == 32'h3000_0000, "R8 unused bits read 0", int'(rd_data), 32'h3000_0000);
        check(phy_ready, "R10 no start without bit 31", int'(phy_ready), 1);
        write_word(32'h2000_0ABC);
        check(slow_mode && !sdio_mode, "R8 slow only", int'({slow_mode, sdio_mode}), 2);
        check(rd_data == 32'h2000_0ABC, "R10 fields stored, idle", int'(rd_data), 32'h2000_0ABC);
        repeat (3) @(negedge clk);
        check(phy_ready && !fc_sync_en, "R10 still idle", int'(phy_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_skip();
        t_max();
        t_relaunch();
        t_modes();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule